// File: doc/BRIEF.md
# Four-Way Microcoded Next-State Sequencer

This block is the control sequencer of a small accumulator processor. It is built as a microprogrammed Moore machine. A 4-bit state register addresses a 16-entry constant control store. Each 40-bit entry holds three things: two condition-select bits, four candidate successor addresses (slot 0 to slot 3), and a 22-bit horizontal control field. The control field drives the datapath strobes directly.

On every clock edge, the first select bit picks the high condition bit, called alpha. Alpha is either the memory wait line or opcode bit 15. The second select bit picks the low condition bit, called beta. Beta is either the accumulator sign bit or opcode bit 14. The index {alpha, beta} chooses which stored slot becomes the next state. A state with unconditional flow stores the same address in all four slots, so its inputs cannot matter. The datapath itself sits outside the block.

The states and their transitions are listed below.
- RESET (0000) goes to FETCH_ADDR.
- FETCH_ADDR (0001) goes to FETCH_REQ.
- FETCH_REQ (0010) waits for Wait to go high, then goes to FETCH_DATA.
- FETCH_DATA (0011) waits for Wait to go low, then goes to FETCH_IR.
- FETCH_IR (0100) waits for Wait to go high, then goes to DECODE.
- DECODE (0101) dispatches on the opcode to LOAD_ADDR, STORE_ADDR, ADD_ADDR or BRANCH_TEST.
- The load path runs LOAD_ADDR (0110), then LOAD_MEM (0111) until Wait goes low, then LOAD_WB (1000), then back to FETCH_ADDR.
- The store path runs STORE_ADDR (1001), then STORE_MEM (1010) until Wait goes low, then back to FETCH_ADDR.
- The add path runs ADD_ADDR (1011), then ADD_MEM (1100) until Wait goes low, then ADD_WB (1101), then back to FETCH_ADDR.
- BRANCH_TEST (1110) goes to BRANCH_TAKE (1111) when the accumulator is negative, and to FETCH_ADDR otherwise. BRANCH_TAKE returns to FETCH_ADDR.

Top module: `useq_top`

## Requirements
- R1: Reset is synchronous and active high. A clock edge with `rst` high puts `state_o` at 0000. In state 0000, bit 0 of `ctrl_o` (PC clear) is the only control bit asserted.
- R2: Each state moves to exactly one of its four stored successors. The choice is the slot whose index is {alpha, beta}, with alpha as the high bit. Alpha is `mem_wait` when its select bit is 0 and `op_hi` when it is 1. Beta is `acc_neg` when its select bit is 0 and `op_lo` when it is 1.
- R3: The fetch path behaves as follows:
  - 0000 goes to 0001, and 0001 goes to 0010.
  - 0010 stays put while `mem_wait` is 0 and goes to 0011 when it is 1.
  - 0011 stays put while `mem_wait` is 1 and goes to 0100 when it is 0.
  - 0100 stays put while `mem_wait` is 0 and goes to 0101 when it is 1.
- R4: From 0101, the value of {`op_hi`, `op_lo`} selects the next state, whatever `mem_wait` and `acc_neg` are:
  - 00 goes to 0110.
  - 01 goes to 1001.
  - 10 goes to 1011.
  - 11 goes to 1110.
- R5: The load path goes 0110 to 0111. 0111 stays put while `mem_wait` is 1 and goes to 1000 when it is 0. 1000 goes to 0001.
- R6: The store path goes 1001 to 1010. 1010 stays put while `mem_wait` is 1 and goes to 0001 when it is 0.
- R7: The add path goes 1011 to 1100. 1100 stays put while `mem_wait` is 1 and goes to 1101 when it is 0. 1101 goes to 0001.
- R8: 1110 goes to 1111 when `acc_neg` is 1 and to 0001 when it is 0. 1111 goes to 0001.
- R9: In the unconditional states (0000, 0001, 0110, 1000, 1001, 1011, 1101 and 1111), all four condition inputs are ignored.
- R10: The control bits of `ctrl_o` are asserted as follows:
  - Bit 1 (PC increment) is asserted only in 0001.
  - Bit 2 (memory request) is asserted only in 0010, 0011, 0110, 0111, 1010, 1011 and 1100.
  - Bit 3 (read/write, 1 = read) is asserted only in 0010, 0011, 0110, 0111, 1011 and 1100, so 1010 requests a write.
  - At most one of PC clear, PC increment and PC load (bit 17) is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_wait | input | 1 | Memory wait handshake (alpha candidate 0) |
| op_hi | input | 1 | Instruction register bit 15 (alpha candidate 1) |
| op_lo | input | 1 | Instruction register bit 14 (beta candidate 1) |
| acc_neg | input | 1 | Accumulator bit 15 (beta candidate 0) |
| state_o | output | 4 | Current state (control store address) |
| ctrl_o | output | 22 | Horizontal control field of the current state |

## Verification
A condition input that is present at a rising edge decides the state one edge later. The control field follows the new state combinationally, with no extra delay. The bench drives the inputs at the falling edge. Its reference model then advances by one step, and both `state_o` and the low control bits are compared at the next falling edge, which is exactly one register stage after the stimulus. Random Wait, opcode and sign values over thousands of cycles drive every instruction path, including stalls of several cycles, both branch outcomes and a reset in mid-run.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int SW    = 4;
    localparam int NSLOT = 4;
    localparam int CW    = 22;
    localparam int DEPTH = 1 << SW;

    typedef enum logic [SW-1:0] {
        S_RESET    = 4'd0,
        S_F_ADDR   = 4'd1,
        S_F_REQ    = 4'd2,
        S_F_DATA   = 4'd3,
        S_F_IR     = 4'd4,
        S_DECODE   = 4'd5,
        S_LD_ADDR  = 4'd6,
        S_LD_MEM   = 4'd7,
        S_LD_WB    = 4'd8,
        S_ST_ADDR  = 4'd9,
        S_ST_MEM   = 4'd10,
        S_AD_ADDR  = 4'd11,
        S_AD_MEM   = 4'd12,
        S_AD_WB    = 4'd13,
        S_BR_TEST  = 4'd14,
        S_BR_TAKE  = 4'd15
    } state_t;

    // control field bit positions
    localparam int CB_PC_CLR    = 0;
    localparam int CB_PC_INC    = 1;
    localparam int CB_REQ       = 2;
    localparam int CB_READ      = 3;
    localparam int CB_PC_OUT_A  = 4;
    localparam int CB_IR_OUT_A  = 5;
    localparam int CB_MBR_OUT_A = 6;
    localparam int CB_R_IN_AC   = 7;
    localparam int CB_AC_ALU_A  = 8;
    localparam int CB_M_ALU_B   = 9;
    localparam int CB_ALU_ADD   = 10;
    localparam int CB_ALU_PASSB = 11;
    localparam int CB_MAR_ADDR  = 12;
    localparam int CB_MBR_DATA  = 13;
    localparam int CB_A_IN_IR   = 14;
    localparam int CB_A_IN_MAR  = 15;
    localparam int CB_DATA_MBR  = 16;
    localparam int CB_A_IN_PC   = 17;
    localparam int CB_R_IN_MBR  = 18;
    localparam int CB_MBR_OUT_M = 19;
    localparam int CB_AC_OUT_R  = 20;
    localparam int CB_ALU_OUT_R = 21;

    typedef logic [NSLOT-1:0][SW-1:0] slots_t;

    typedef struct packed {
        logic          sel_a;
        logic          sel_b;
        slots_t        nxt;
        logic [CW-1:0] ctl;
    } uword_t;

    function automatic slots_t mk_slots(state_t s0, state_t s1, state_t s2, state_t s3);
        slots_t r;
        r[0] = s0;
        r[1] = s1;
        r[2] = s2;
        r[3] = s3;
        return r;
    endfunction

    function automatic slots_t all_to(state_t s);
        return mk_slots(s, s, s, s);
    endfunction

    function automatic uword_t build_word(state_t s);
        uword_t w;
        w = '0;
        unique case (s)
            S_RESET: begin
                w.nxt = all_to(S_F_ADDR);
                w.ctl[CB_PC_CLR] = 1'b1;
            end
            S_F_ADDR: begin
                w.nxt = all_to(S_F_REQ);
                w.ctl[CB_PC_OUT_A] = 1'b1;
                w.ctl[CB_A_IN_MAR] = 1'b1;
                w.ctl[CB_PC_INC]   = 1'b1;
            end
            S_F_REQ: begin
                w.nxt = mk_slots(S_F_REQ, S_F_REQ, S_F_DATA, S_F_DATA);
                w.ctl[CB_MAR_ADDR] = 1'b1;
                w.ctl[CB_READ]     = 1'b1;
                w.ctl[CB_REQ]      = 1'b1;
            end
            S_F_DATA: begin
                w.nxt = mk_slots(S_F_IR, S_F_IR, S_F_DATA, S_F_DATA);
                w.ctl[CB_MAR_ADDR] = 1'b1;
                w.ctl[CB_READ]     = 1'b1;
                w.ctl[CB_REQ]      = 1'b1;
                w.ctl[CB_DATA_MBR] = 1'b1;
            end
            S_F_IR: begin
                w.nxt = mk_slots(S_F_IR, S_F_IR, S_DECODE, S_DECODE);
                w.ctl[CB_MBR_OUT_A] = 1'b1;
                w.ctl[CB_A_IN_IR]   = 1'b1;
            end
            S_DECODE: begin
                w.sel_a = 1'b1;
                w.sel_b = 1'b1;
                w.nxt = mk_slots(S_LD_ADDR, S_ST_ADDR, S_AD_ADDR, S_BR_TEST);
                w.ctl[CB_IR_OUT_A] = 1'b1;
                w.ctl[CB_A_IN_MAR] = 1'b1;
            end
            S_LD_ADDR, S_AD_ADDR: begin
                w.nxt = all_to(s == S_LD_ADDR ? S_LD_MEM : S_AD_MEM);
                w.ctl[CB_MAR_ADDR] = 1'b1;
                w.ctl[CB_READ]     = 1'b1;
                w.ctl[CB_REQ]      = 1'b1;
            end
            S_LD_MEM: begin
                w.nxt = mk_slots(S_LD_WB, S_LD_WB, S_LD_MEM, S_LD_MEM);
                w.ctl[CB_MAR_ADDR] = 1'b1;
                w.ctl[CB_READ]     = 1'b1;
                w.ctl[CB_REQ]      = 1'b1;
                w.ctl[CB_DATA_MBR] = 1'b1;
            end
            S_AD_MEM: begin
                w.nxt = mk_slots(S_AD_WB, S_AD_WB, S_AD_MEM, S_AD_MEM);
                w.ctl[CB_MAR_ADDR] = 1'b1;
                w.ctl[CB_READ]     = 1'b1;
                w.ctl[CB_REQ]      = 1'b1;
                w.ctl[CB_DATA_MBR] = 1'b1;
            end
            S_LD_WB: begin
                w.nxt = all_to(S_F_ADDR);
                w.ctl[CB_MBR_OUT_M] = 1'b1;
                w.ctl[CB_M_ALU_B]   = 1'b1;
                w.ctl[CB_ALU_PASSB] = 1'b1;
                w.ctl[CB_ALU_OUT_R] = 1'b1;
                w.ctl[CB_R_IN_AC]   = 1'b1;
            end
            S_ST_ADDR: begin
                w.nxt = all_to(S_ST_MEM);
                w.ctl[CB_AC_OUT_R] = 1'b1;
                w.ctl[CB_R_IN_MBR] = 1'b1;
            end
            S_ST_MEM: begin
                w.nxt = mk_slots(S_F_ADDR, S_F_ADDR, S_ST_MEM, S_ST_MEM);
                w.ctl[CB_MAR_ADDR] = 1'b1;
                w.ctl[CB_MBR_DATA] = 1'b1;
                w.ctl[CB_REQ]      = 1'b1;
            end
            S_AD_WB: begin
                w.nxt = all_to(S_F_ADDR);
                w.ctl[CB_AC_ALU_A]  = 1'b1;
                w.ctl[CB_MBR_OUT_M] = 1'b1;
                w.ctl[CB_M_ALU_B]   = 1'b1;
                w.ctl[CB_ALU_ADD]   = 1'b1;
                w.ctl[CB_ALU_OUT_R] = 1'b1;
                w.ctl[CB_R_IN_AC]   = 1'b1;
            end
            S_BR_TEST: begin
                w.nxt = mk_slots(S_F_ADDR, S_BR_TAKE, S_F_ADDR, S_BR_TAKE);
            end
            S_BR_TAKE: begin
                w.nxt = all_to(S_F_ADDR);
                w.ctl[CB_IR_OUT_A] = 1'b1;
                w.ctl[CB_A_IN_PC]  = 1'b1;
            end
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  logic [SW-1:0] addr,
    output uword_t        word
);
    uword_t rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign rom[i] = build_word(state_t'(SW'(i)));
    end

    assign word = rom[addr];
endmodule

// File: rtl/useq_cond_sel.sv
module useq_cond_sel (
    input  logic       sel_a,
    input  logic       sel_b,
    input  logic       mem_wait,
    input  logic       op_hi,
    input  logic       op_lo,
    input  logic       acc_neg,
    output logic [1:0] idx
);
    logic alpha;
    logic beta;

    always_comb begin
        alpha = sel_a ? op_hi : mem_wait;
        beta  = sel_b ? op_lo : acc_neg;
        idx   = {alpha, beta};
    end
endmodule

// File: rtl/useq_slot_pick.sv
module useq_slot_pick
    import useq_pkg::*;
(
    input  slots_t                     nxt,
    input  logic [$clog2(NSLOT)-1:0]   idx,
    output logic [SW-1:0]              target
);
    always_comb begin
        target = nxt[idx];
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          mem_wait,
    input  logic          op_hi,
    input  logic          op_lo,
    input  logic          acc_neg,
    output logic [SW-1:0] state_o,
    output logic [CW-1:0] ctrl_o
);
    state_t        state_q;
    uword_t        cur;
    logic [1:0]    idx;
    logic [SW-1:0] target;

    useq_store u_store (
        .addr (state_q),
        .word (cur)
    );

    useq_cond_sel u_cond (
        .sel_a    (cur.sel_a),
        .sel_b    (cur.sel_b),
        .mem_wait (mem_wait),
        .op_hi    (op_hi),
        .op_lo    (op_lo),
        .acc_neg  (acc_neg),
        .idx      (idx)
    );

    useq_slot_pick u_pick (
        .nxt    (cur.nxt),
        .idx    (idx),
        .target (target)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_RESET;
        else     state_q <= state_t'(target);
    end

    // outputs
    always_comb begin
        state_o = state_q;
        ctrl_o  = cur.ctl;
    end

    a_r1_reset_loads_zero: assert property (@(posedge clk)
        rst |=> (state_o == 4'b0000));

    a_r3_fetch_req_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_F_REQ && !mem_wait) |=> (state_q == S_F_REQ));

    a_r4_decode_dispatch: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_DECODE) |=> (state_q inside {S_LD_ADDR, S_ST_ADDR, S_AD_ADDR, S_BR_TEST}));

    a_r8_branch_not_taken: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_BR_TEST && !acc_neg) |=> (state_q == S_F_ADDR));

    a_r9_load_wb_returns: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_LD_WB) |=> (state_q == S_F_ADDR));

    a_r10_pc_ops_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl_o[CB_PC_CLR], ctrl_o[CB_PC_INC], ctrl_o[CB_A_IN_PC]}));
endmodule

// File: tb/test_useq_top.sv
module test_useq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_wait = 1'b0;
    logic        op_hi = 1'b0;
    logic        op_lo = 1'b0;
    logic        acc_neg = 1'b0;
    logic [3:0]  state_o;
    logic [21:0] ctrl_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    useq_top i_useq_top (
        .clk      (clk),
        .rst      (rst),
        .mem_wait (mem_wait),
        .op_hi    (op_hi),
        .op_lo    (op_lo),
        .acc_neg  (acc_neg),
        .state_o  (state_o),
        .ctrl_o   (ctrl_o)
    );

    always #5 clk = ~clk;

    // reference: successor per requirement text
    function automatic int ref_next(int s, bit w, bit hi, bit lo, bit neg);
        case (s)
            0:  return 1;
            1:  return 2;
            2:  return w ? 3 : 2;
            3:  return w ? 3 : 4;
            4:  return w ? 5 : 4;
            5:  return hi ? (lo ? 14 : 11) : (lo ? 9 : 6);
            6:  return 7;
            7:  return w ? 7 : 8;
            8:  return 1;
            9:  return 10;
            10: return w ? 10 : 1;
            11: return 12;
            12: return w ? 12 : 13;
            13: return 1;
            14: return neg ? 15 : 1;
            default: return 1;
        endcase
    endfunction

    function automatic string tag_of(int prev, bit was_rst);
        if (was_rst) return "R1";
        case (prev)
            0, 1:        return "R3 R9 R2";
            2, 3, 4:     return "R3 R2";
            5:           return "R4 R2";
            6, 8:        return "R5 R9";
            7:           return "R5 R2";
            9:           return "R6 R9";
            10:          return "R6 R2";
            11, 13:      return "R7 R9";
            12:          return "R7 R2";
            14:          return "R8 R2";
            default:     return "R8 R9";
        endcase
    endfunction

    function automatic logic [3:0] ref_ctl(int s);
        logic [3:0] c;
        c[0] = (s == 0);
        c[1] = (s == 1);
        c[2] = (s inside {2, 3, 6, 7, 10, 11, 12});
        c[3] = (s inside {2, 3, 6, 7, 11, 12});
        return c;
    endfunction

    task automatic compare(int exp_s, string tag);
        checks++;
        if (state_o !== 4'(exp_s)) begin
            fails++;
            $display("FAIL %s state: actual %0d expected %0d", tag, state_o, exp_s);
        end
        checks++;
        if (ctrl_o[3:0] !== ref_ctl(exp_s)) begin
            fails++;
            $display("FAIL R10 ctrl[3:0] in state %0d: actual %b expected %b",
                     exp_s, ctrl_o[3:0], ref_ctl(exp_s));
        end
    endtask

    initial begin
        int exp_s;
        int prev;
        bit was_rst;
        @(negedge clk);
        exp_s = 0;
        compare(exp_s, "R1");
        rst = 1'b0;
        prev = exp_s;
        exp_s = ref_next(exp_s, mem_wait, op_hi, op_lo, acc_neg);
        was_rst = 1'b0;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            compare(exp_s, tag_of(prev, was_rst));
            mem_wait = 1'($urandom_range(0, 1));
            op_hi    = 1'($urandom_range(0, 1));
            op_lo    = 1'($urandom_range(0, 1));
            acc_neg  = 1'($urandom_range(0, 1));
            rst      = (cyc == 1500 || cyc == 2900);
            prev     = exp_s;
            was_rst  = rst;
            exp_s    = rst ? 0 : ref_next(exp_s, mem_wait, op_hi, op_lo, acc_neg);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule